// File: doc/BRIEF.md
# Five-Way Locality Ownership Arbiter

This block decides which of several software localities owns a shared device register interface at any moment. Each locality sees the device through its own 4 KB address window. At the start of every window sits an 8-bit ownership register. A locality writes a claim bit there to ask for the interface and writes the ownership bit to give it back. The arbiter keeps one flag per locality for an outstanding claim. It holds the identity of the current owner and hands the interface to the highest-numbered claimant whenever it falls free.

For a while after reset the block reports nothing: every read of the ownership register returns zero, and writes are dropped, until a parameterised start-up delay has run out. After that the register reports a ready bit, whether the reading locality is the owner, whether that locality has a claim outstanding, and (to the owner only) whether any other locality is waiting. A one-cycle change strobe goes to the interrupt logic each time ownership moves.

Top module: `locality_owner_arb`

## Requirements
- R1: After reset, until INIT_CYCLES rising edges have passed, every read returns 0x00, owner_valid is 0 and writes have no effect. From then on bit 7 (ready) of every ownership register reads 1.
- R2: Address bits [14:12] select the locality and bits [11:0] the offset. Only offset 0x000 of localities 0 to 4 is decoded. Reads anywhere else return 0x00, and writes there change nothing.
- R3: A read of the ownership register returns bit 7 = ready, bit 5 = this locality owns the interface, bit 2 = claim waiting from another locality, and bit 1 = this locality's own claim outstanding. All other bits read 0.
- R4: A write with bit 1 set from a non-owner sets that locality's claim on the write edge. When nobody owns the interface, the claim is granted on the following edge and the claim flag clears.
- R5: A write with bit 5 set from the owner releases ownership on the write edge.
- R6: When the interface is free and claims are waiting, the highest-numbered claiming locality is granted on the next edge.
- R7: Bit 2 reads 1 only in the owner's register, and only while some other locality has a claim outstanding.
- R8: A claim written by the current owner is ignored. A release written by a locality that is not the owner is ignored.
- R9: loc_change is high for exactly the one cycle after each edge on which ownership changes, either a grant or a release.
- R10: owner_valid shows whether any locality owns the interface, and owner_id gives its number while owner_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 15 | Register address: locality in [14:12], offset in [11:0] |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| owner_valid | output | 1 | Some locality owns the interface |
| owner_id | output | 3 | Number of the owning locality |
| loc_change | output | 1 | One-cycle strobe after ownership changes |

## Verification
A claim or release takes effect on the edge that samples the write. Its claim bit and loc_change are therefore visible right after that edge, and a grant appears after one more edge. The bench drives on falling edges and reads the combinational read port just after a falling edge. Each table step is one write edge followed by one idle edge, so both the claim and any resulting grant have settled before the probe. The directed tests sample loc_change one edge apart to pin its single-cycle width. They count edges from reset release to find the exact cycle in which ready rises.

// File: rtl/locarb_pkg.sv
package locarb_pkg;
   // bit positions inside the per-locality ownership register
   localparam int unsigned READY_BIT = 7;
   localparam int unsigned OWN_BIT   = 5;
   localparam int unsigned WAIT_BIT  = 2;
   localparam int unsigned CLAIM_BIT = 1;
endpackage

// File: rtl/locarb_init_gate.sv
module locarb_init_gate #(
   parameter int unsigned INIT_CYCLES = 32
) (
   input  logic clk,
   input  logic rst_n,
   output logic ready
);
   localparam int unsigned CNT_W = $clog2(INIT_CYCLES + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(INIT_CYCLES);

   initial begin
      if (INIT_CYCLES < 1) $error("INIT_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign ready = (cnt_q == LIMIT);

   // R1
   ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);
endmodule

// File: rtl/locarb_claim_bank.sv
module locarb_claim_bank #(
   parameter int unsigned NUM_LOC = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LOC-1:0] set_vec,
   input  logic [NUM_LOC-1:0] clr_vec,
   output logic [NUM_LOC-1:0] claim_vec
);
   for (genvar g = 0; g < NUM_LOC; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) claim_vec[g] <= 1'b0;
         else        claim_vec[g] <= (claim_vec[g] | set_vec[g]) & ~clr_vec[g];
      end

      // R4
      claim_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (set_vec[g] && !clr_vec[g]) |=> claim_vec[g]);
   end
endmodule

// File: rtl/locarb_grant.sv
module locarb_grant #(
   parameter int unsigned NUM_LOC = 5,
   parameter int unsigned LOC_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LOC-1:0] claim_vec,
   input  logic               release_req,
   output logic [NUM_LOC-1:0] grant_clr,
   output logic               own_v,
   output logic [LOC_W-1:0]   own_id,
   output logic               loc_change
);
   logic             hi_any;
   logic [LOC_W-1:0] hi_id;
   logic             nxt_v;
   logic [LOC_W-1:0] nxt_id;

   // highest-numbered claimant: later iterations override earlier ones
   always_comb begin
      hi_any = 1'b0;
      hi_id  = '0;
      for (int i = 0; i < NUM_LOC; i++) begin
         if (claim_vec[i]) begin
            hi_any = 1'b1;
            hi_id  = LOC_W'(i);
         end
      end
   end

   always_comb begin
      nxt_v     = own_v;
      nxt_id    = own_id;
      grant_clr = '0;
      if (own_v && release_req) begin
         nxt_v = 1'b0;
      end else if (!own_v && hi_any) begin
         nxt_v     = 1'b1;
         nxt_id    = hi_id;
         grant_clr = NUM_LOC'(1) << hi_id;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_v      <= 1'b0;
         own_id     <= '0;
         loc_change <= 1'b0;
      end else begin
         own_v      <= nxt_v;
         own_id     <= nxt_id;
         loc_change <= (nxt_v != own_v) || (nxt_v && (nxt_id != own_id));
      end
   end

   // R6
   grant_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_v && (|claim_vec)) |=> own_v);

   // R8
   owner_no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      own_v |-> !claim_vec[own_id]);

   // R9
   change_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loc_change |-> ((own_v != $past(own_v)) || (own_id != $past(own_id))));
endmodule

// File: rtl/locality_owner_arb.sv
module locality_owner_arb #(
   parameter int unsigned NUM_LOC     = 5,
   parameter int unsigned ADDR_W      = 15,
   parameter int unsigned WIN_SHIFT   = 12,
   parameter int unsigned INIT_CYCLES = 32
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [ADDR_W-1:0]                    bus_addr,
   input  logic                                 bus_wr,
   input  logic [7:0]                           bus_wdata,
   output logic [7:0]                           bus_rdata,
   output logic                                 owner_valid,
   output logic [ADDR_W-WIN_SHIFT-1:0]          owner_id,
   output logic                                 loc_change
);
   import locarb_pkg::*;

   localparam int unsigned LOC_W = ADDR_W - WIN_SHIFT;

   initial begin
      if (LOC_W < 1)           $error("address leaves no locality bits");
      if (NUM_LOC > (1 << LOC_W)) $error("NUM_LOC exceeds locality field");
      if (NUM_LOC < 2)         $error("NUM_LOC must be at least 2");
   end

   logic               ready;
   logic [LOC_W-1:0]   sel_loc;
   logic               hit;
   logic               wr_ok;
   logic [NUM_LOC-1:0] set_vec;
   logic [NUM_LOC-1:0] grant_clr;
   logic [NUM_LOC-1:0] claim_vec;
   logic               release_req;
   logic               sel_owner;

   assign sel_loc = bus_addr[ADDR_W-1:WIN_SHIFT];
   assign hit     = (bus_addr[WIN_SHIFT-1:0] == '0) &&
                    ({1'b0, sel_loc} < (LOC_W+1)'(NUM_LOC));
   assign wr_ok   = bus_wr && hit && ready;
   assign sel_owner = owner_valid && (owner_id == sel_loc);

   for (genvar g = 0; g < NUM_LOC; g++) begin : g_set
      assign set_vec[g] = wr_ok && (sel_loc == LOC_W'(g)) &&
                          bus_wdata[CLAIM_BIT] &&
                          !(owner_valid && (owner_id == LOC_W'(g)));
   end

   assign release_req = wr_ok && bus_wdata[OWN_BIT] && sel_owner;

   locarb_init_gate #(.INIT_CYCLES(INIT_CYCLES)) i_init (
      .clk   (clk),
      .rst_n (rst_n),
      .ready (ready)
   );

   locarb_claim_bank #(.NUM_LOC(NUM_LOC)) i_claims (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_vec   (set_vec),
      .clr_vec   (grant_clr),
      .claim_vec (claim_vec)
   );

   locarb_grant #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) i_grant (
      .clk         (clk),
      .rst_n       (rst_n),
      .claim_vec   (claim_vec),
      .release_req (release_req),
      .grant_clr   (grant_clr),
      .own_v       (owner_valid),
      .own_id      (owner_id),
      .loc_change  (loc_change)
   );

   always_comb begin
      bus_rdata = 8'h00;
      if (ready && hit) begin
         bus_rdata[READY_BIT] = 1'b1;
         bus_rdata[OWN_BIT]   = sel_owner;
         bus_rdata[WAIT_BIT]  = sel_owner && (|claim_vec);
         bus_rdata[CLAIM_BIT] = claim_vec[sel_loc];
      end
   end

   // R10
   owner_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      owner_valid |-> ({1'b0, owner_id} < (LOC_W+1)'(NUM_LOC)));

   // R1
   quiet_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (!owner_valid && (bus_rdata == 8'h00)));

   // R7
   wait_owner_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[WAIT_BIT] |-> bus_rdata[OWN_BIT]);
endmodule

// File: tb/test_locality_owner_arb.sv
module test_locality_owner_arb;
   localparam int CLK_PERIOD = 10;
   localparam int INIT       = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        owner_valid;
   logic [2:0]  owner_id;
   logic        loc_change;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   locality_owner_arb #(.INIT_CYCLES(INIT)) i_locality_owner_arb (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .owner_valid(owner_valid), .owner_id(owner_id), .loc_change(loc_change)
   );

   // {wloc, wdata, probe loc, expected read, expected valid, expected id}
   localparam int NV = 12;
   localparam logic [25:0] VEC [NV] = '{
      {3'd2, 8'h02, 3'd2, 8'hA0, 1'b1, 3'd2},  // R4 idle claim granted
      {3'd4, 8'h02, 3'd2, 8'hA4, 1'b1, 3'd2},  // R7 owner sees waiting
      {3'd1, 8'h02, 3'd1, 8'h82, 1'b1, 3'd2},  // R3 own claim bit
      {3'd2, 8'h02, 3'd2, 8'hA4, 1'b1, 3'd2},  // R8 owner claim ignored
      {3'd1, 8'h20, 3'd1, 8'h82, 1'b1, 3'd2},  // R8 foreign release ignored
      {3'd2, 8'h20, 3'd4, 8'hA4, 1'b1, 3'd4},  // R6 highest wins
      {3'd4, 8'h20, 3'd1, 8'hA0, 1'b1, 3'd1},  // R5 release, next granted
      {3'd1, 8'h20, 3'd1, 8'h80, 1'b0, 3'd0},  // R5 release, none waiting
      {3'd0, 8'h02, 3'd0, 8'hA0, 1'b1, 3'd0},  // R4 locality 0
      {3'd3, 8'h22, 3'd3, 8'h82, 1'b1, 3'd0},  // R8 mixed write
      {3'd0, 8'h20, 3'd3, 8'hA0, 1'b1, 3'd3},  // R6 handover
      {3'd5, 8'h02, 3'd3, 8'hA0, 1'b1, 3'd3}   // R2 unmapped locality
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_op(input logic [14:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic idle();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic probe(input logic [14:0] a, input string req, input logic [7:0] exp);
      bus_addr = a; #1;
      check(req, bus_rdata, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 read at reset", bus_rdata, 8'h00);
      check("R1 owner at reset", {7'd0, owner_valid}, 8'h00);
      // claim written during start-up: must be dropped
      bus_addr = {3'd0, 12'h000}; bus_wdata = 8'h02; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
      repeat (INIT - 2) @(posedge clk);
      @(negedge clk);
      probe({3'd0, 12'h000}, "R1 still hidden", 8'h00);
      @(posedge clk); @(negedge clk);
      probe({3'd0, 12'h000}, "R1 ready, early claim dropped", 8'h80);
      check("R1 no owner", {7'd0, owner_valid}, 8'h00);

      for (int k = 0; k < NV; k++) begin
         wr_op({VEC[k][25:23], 12'h000}, VEC[k][22:15]);
         idle();
         probe({VEC[k][14:12], 12'h000}, $sformatf("R3 table step %0d", k), VEC[k][11:4]);
         check($sformatf("R10 valid step %0d", k), {7'd0, owner_valid}, {7'd0, VEC[k][3]});
         if (VEC[k][3])
            check($sformatf("R10 id step %0d", k), {5'd0, owner_id}, {5'd0, VEC[k][2:0]});
      end

      probe({3'd5, 12'h000}, "R2 locality 5 reads zero", 8'h00);
      probe({3'd7, 12'h000}, "R2 locality 7 reads zero", 8'h00);
      probe({3'd3, 12'h004}, "R2 nonzero offset reads zero", 8'h00);

      // write to nonzero offset of locality 0 must not claim
      wr_op({3'd0, 12'h004}, 8'h02);
      idle();
      probe({3'd0, 12'h000}, "R2 offset write ignored", 8'h80);
      probe({3'd3, 12'h000}, "R7 no waiter", 8'hA0);

      // loc_change timing on release then grant
      wr_op({3'd3, 12'h000}, 8'h20);
      check("R9 pulse on release", {7'd0, loc_change}, 8'h01);
      check("R5 released at write edge", {7'd0, owner_valid}, 8'h00);
      idle();
      check("R9 pulse one cycle", {7'd0, loc_change}, 8'h00);
      wr_op({3'd2, 12'h000}, 8'h02);
      check("R9 no pulse on claim", {7'd0, loc_change}, 8'h00);
      probe({3'd2, 12'h000}, "R4 claim visible", 8'h82);
      idle();
      check("R9 pulse on grant", {7'd0, loc_change}, 8'h01);
      check("R4 granted id", {5'd0, owner_id}, 8'h02);
      idle();
      check("R9 grant pulse ends", {7'd0, loc_change}, 8'h00);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule